// File: doc/BRIEF.md
# Divided Clock Output Channel

This block produces one divided clock output from a choice of two source clocks, a slow 32768 Hz reference and a fast source of about 4 MHz. A single 8-bit control word chooses the source and two dividers, and it turns the output on or off. The block runs on one system clock. Each source is presented as a one-cycle tick input, asserted once for every edge of that source, so a division ratio of T makes each output phase last exactly T source ticks. On the fast path the ticks first pass through a pre-divider. Its ratios are powers of two, except the top code, which gives 122. A power-of-two post-divider follows. On the slow path the pre-divider is skipped entirely.

The output always starts with its high phase. A new divider or source setting is taken up only at the end of a whole output period, so reprogramming never produces a shortened pulse. Turning the output off lets the current period finish, high and low phase both, and then holds the output low. A system instantiates one channel for each output pin, one control word each.

Top module: `clkout_channel`

## Requirements
- R1: While reset is asserted and after reset is released with the enable bit clear, the output is low.
- R2: Control word layout: bit 0 enables the output, bits 3:1 hold the post-divider code, bit 4 selects the source (0 = slow 32768 Hz tick, 1 = fast tick), and bits 7:5 hold the pre-divider code.
- R3: With the fast source selected, pre-divider codes 0 to 6 divide by 2 to the power of the code, and code 7 divides by 122.
- R4: With the slow source selected, the pre-divider code has no effect, and the ratio equals the post-divider ratio alone.
- R5: The post-divider divides by 2 to the power of its 3-bit code, from 1 to 128.
- R6: Each output period is a high phase followed by a low phase. Each phase lasts exactly (pre ratio × post ratio) ticks of the selected source.
- R7: After the enable bit is set, the output goes high on the first tick of the selected source, and that first high phase has the full length.
- R8: When the enable bit is cleared, the current high and low phases run to completion. The output then stays low and does not rise again.
- R9: A change to the source or divider fields during a period takes effect only at the next period boundary. The period in progress keeps its old length.
- R10: While the channel is stopped with the enable bit clear, the output stays low whatever the other fields and the tick inputs do.
- R11: The output changes only on the clock edge at which a tick of the active source is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reg | input | 8 | Control word: enable, post code, source select, pre code |
| slow_tick | input | 1 | One-cycle pulse per edge of the 32768 Hz source |
| fast_tick | input | 1 | One-cycle pulse per edge of the fast source |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The bench uses the default parameters: 3-bit pre and post codes and a top pre-divider ratio of 122. With these, every pre-divider code, including the non-power-of-two one, can be measured against the fast tick held high on every cycle. A slow tick every third cycle can be told apart from the fast tick, so the bypass of the pre-divider on the slow path is visible as phase lengths that are multiples of three. A post ratio of 8 gives periods long enough to reprogram or disable the block part way through a high phase and observe the boundary behaviour.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_FAST = 1'b1
  } src_sel_e;

  // Pre-divider ratio for a code: powers of two, the top code uses last_ratio
  function automatic int unsigned pre_ratio(int unsigned code,
                                            int unsigned code_max,
                                            int unsigned last_ratio);
    return (code == code_max) ? last_ratio : (32'd1 << code);
  endfunction

endpackage

// File: rtl/clkout_prediv.sv
module clkout_prediv
  import clkout_pkg::*;
#(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned CNT_W      = 7,
  parameter int unsigned LAST_RATIO = 122
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              bypass,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              pre_tick
);

  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  always_comb begin
    at_end   = (cnt_q == CNT_W'(pre_ratio(int'(code), CODE_MAX, LAST_RATIO) - 1));
    pre_tick = step & (bypass | at_end);
    cnt_d    = cnt_q;
    if (hold || bypass) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/clkout_postdiv.sv
module clkout_postdiv #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              wrap,
  output logic              level_d,
  output logic [CNT_W-1:0]  cnt_q
);

  logic [CNT_W:0]   lim;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    // Counter spans one full output period: 2 * 2^code pre-divided ticks
    lim   = ((CNT_W+1)'(1) << (int'(code) + 1)) - 1'b1;
    wrap  = step & (cnt_q == lim[CNT_W-1:0]);
    cnt_d = cnt_q;
    if (hold) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
    // High during the first half of the period
    level_d = ~cnt_d[code];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/clkout_channel.sv
module clkout_channel
  import clkout_pkg::*;
#(
  parameter int unsigned PRE_CODE_W     = 3,
  parameter int unsigned POST_CODE_W    = 3,
  parameter int unsigned LAST_PRE_RATIO = 122,
  localparam int unsigned REG_W         = PRE_CODE_W + POST_CODE_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] cfg_reg,
  input  logic             slow_tick,
  input  logic             fast_tick,
  output logic             clk_out
);

  localparam int unsigned PRE_MAX    = (1 << PRE_CODE_W) - 1;
  localparam int unsigned PRE_POW    = 1 << (PRE_MAX - 1);
  localparam int unsigned PRE_BIG    = (LAST_PRE_RATIO > PRE_POW) ? LAST_PRE_RATIO : PRE_POW;
  localparam int unsigned PRE_CNT_W  = $clog2(PRE_BIG);
  localparam int unsigned POST_CNT_W = 1 << POST_CODE_W;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned POST_LSB   = 1;
  localparam int unsigned SEL_BIT    = POST_CODE_W + 1;
  localparam int unsigned PRE_LSB    = POST_CODE_W + 2;

  // Decoded control word
  logic                   reg_en;
  src_sel_e               reg_sel;
  logic [PRE_CODE_W-1:0]  reg_pre;
  logic [POST_CODE_W-1:0] reg_post;

  // Active settings, loaded only at a period boundary or while stopped
  src_sel_e               act_sel_q, act_sel_d;
  logic [PRE_CODE_W-1:0]  act_pre_q, act_pre_d;
  logic [POST_CODE_W-1:0] act_post_q, act_post_d;
  logic                   run_q, run_d;
  logic                   out_q, out_d;

  logic                   tick_act, tick_reg, pre_tick, boundary, level_d, load;
  logic [POST_CNT_W-1:0]  post_cnt;

  always_comb begin
    reg_en   = cfg_reg[EN_BIT];
    reg_sel  = src_sel_e'(cfg_reg[SEL_BIT]);
    reg_pre  = cfg_reg[PRE_LSB +: PRE_CODE_W];
    reg_post = cfg_reg[POST_LSB +: POST_CODE_W];
    tick_act = (act_sel_q == SRC_FAST) ? fast_tick : slow_tick;
    tick_reg = (reg_sel == SRC_FAST) ? fast_tick : slow_tick;
  end

  clkout_prediv #(
    .CODE_W     (PRE_CODE_W),
    .CNT_W      (PRE_CNT_W),
    .LAST_RATIO (LAST_PRE_RATIO)
  ) prediv_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (~run_q),
    .bypass   (act_sel_q == SRC_SLOW),
    .step     (run_q & tick_act),
    .code     (act_pre_q),
    .pre_tick (pre_tick)
  );

  clkout_postdiv #(
    .CODE_W (POST_CODE_W),
    .CNT_W  (POST_CNT_W)
  ) postdiv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (~run_q),
    .step    (pre_tick),
    .code    (act_post_q),
    .wrap    (boundary),
    .level_d (level_d),
    .cnt_q   (post_cnt)
  );

  // Next-state logic
  always_comb begin
    load       = ~run_q | boundary;
    act_sel_d  = load ? reg_sel  : act_sel_q;
    act_pre_d  = load ? reg_pre  : act_pre_q;
    act_post_d = load ? reg_post : act_post_q;
    if (run_q) begin
      run_d = ~(boundary & ~reg_en);
    end else begin
      run_d = reg_en & tick_reg;
    end
    out_d = run_d & level_d;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel_q  <= SRC_SLOW;
      act_pre_q  <= '0;
      act_post_q <= '0;
      run_q      <= 1'b0;
      out_q      <= 1'b0;
    end else begin
      if (load) begin
        act_sel_q  <= act_sel_d;
        act_pre_q  <= act_pre_d;
        act_post_q <= act_post_d;
      end
      run_q <= run_d;
      out_q <= out_d;
    end
  end

  assign clk_out = out_q;

endmodule

// File: rtl/clkout_channel_chk.sv
module clkout_channel_chk #(
  parameter int unsigned PRE_CODE_W  = 3,
  parameter int unsigned POST_CODE_W = 3,
  parameter int unsigned POST_CNT_W  = 8,
  parameter int unsigned REG_W       = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [REG_W-1:0]       cfg_reg,
  input logic                   slow_tick,
  input logic                   fast_tick,
  input logic                   clk_out,
  input logic                   run_q,
  input logic                   boundary,
  input logic                   act_sel_q,
  input logic [PRE_CODE_W-1:0]  act_pre_q,
  input logic [POST_CODE_W-1:0] act_post_q,
  input logic [POST_CNT_W-1:0]  post_cnt
);

  AST_IDLE_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_reg[0] && !clk_out && !run_q) |=> !clk_out); // R10

  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out != $past(clk_out)) |-> $past(slow_tick || fast_tick)); // R11

  AST_CFG_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && !$past(boundary)) |-> $stable({act_sel_q, act_pre_q, act_post_q})); // R9

  AST_RISE_AT_PERIOD_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> (post_cnt == '0)); // R6

  AST_POST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(post_cnt) >> (int'(act_post_q) + 1)) == 0); // R5

  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(boundary) && !$past(cfg_reg[0]))); // R8

endmodule

bind clkout_channel clkout_channel_chk #(
  .PRE_CODE_W  (PRE_CODE_W),
  .POST_CODE_W (POST_CODE_W),
  .POST_CNT_W  (POST_CNT_W),
  .REG_W       (REG_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_reg    (cfg_reg),
  .slow_tick  (slow_tick),
  .fast_tick  (fast_tick),
  .clk_out    (clk_out),
  .run_q      (run_q),
  .boundary   (boundary),
  .act_sel_q  (act_sel_q),
  .act_pre_q  (act_pre_q),
  .act_post_q (act_post_q),
  .post_cnt   (post_cnt)
);

// File: tb/clkout_channel_tb_top.sv
`timescale 1ns/1ps
module clkout_channel_tb_top;

  localparam int CAP = 20000;

  logic       clk;
  logic       rst_n;
  logic [7:0] cfg_reg;
  logic       slow_tick;
  logic       fast_tick;
  logic       clk_out;
  logic       fast_on;
  logic       slow_on;
  int         checks;
  int         errors;

  clkout_channel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_reg   (cfg_reg),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick),
    .clk_out   (clk_out)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  // Tick sources: fast every cycle, slow every third cycle
  initial begin
    int gap;
    gap       = 0;
    fast_tick = 1'b0;
    slow_tick = 1'b0;
    forever begin
      @(negedge clk);
      fast_tick = fast_on;
      slow_tick = slow_on && (gap == 0);
      gap       = (gap == 2) ? 0 : gap + 1;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] word(input int pre, input int sel, input int post, input int en);
    return {3'(pre), 1'(sel), 3'(post), 1'(en)};
  endfunction

  task automatic restart();
    @(negedge clk);
    rst_n   = 1'b0;
    cfg_reg = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Called at a negedge; returns at the first negedge where the output is high
  task automatic wait_high(output int waited);
    waited = 0;
    while (clk_out !== 1'b1 && waited < CAP) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic count_phase(input logic lvl, output int n);
    n = 0;
    while (clk_out === lvl && n < CAP) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int pre, input int sel, input int post,
                         input int exp, input string req);
    int w, hi, lo, hi2;
    restart();
    cfg_reg = word(pre, sel, post, 1);
    wait_high(w);
    count_phase(1'b1, hi);
    count_phase(1'b0, lo);
    count_phase(1'b1, hi2);
    check(hi == exp, {req, " R7 first high phase"}, hi, exp);
    check(lo == exp, {req, " low phase"}, lo, exp);
    check(hi2 == exp, {req, " second high phase"}, hi2, exp);
  endtask

  task automatic t_reset();
    restart();
    check(clk_out == 1'b0, "R1 output low after reset", int'(clk_out), 0);
    repeat (5) @(negedge clk);
    check(clk_out == 1'b0, "R1 output low with enable clear", int'(clk_out), 0);
  endtask

  task automatic t_idle();
    int highs;
    restart();
    highs = 0;
    cfg_reg = word(7, 1, 0, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    cfg_reg = word(0, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    check(highs == 0, "R10 R2 disabled channel output", highs, 0);
  endtask

  task automatic t_fast_pre();
    for (int c = 0; c < 7; c++) measure(c, 1, 0, 1 << c, "R3 pre code");
    measure(7, 1, 0, 122, "R3 pre code 7");
  endtask

  task automatic t_post();
    measure(0, 1, 1, 2,   "R5 post code 1");
    measure(0, 1, 4, 16,  "R5 post code 4");
    measure(0, 1, 7, 128, "R5 post code 7");
    measure(7, 1, 2, 488, "R6 pre 7 with post 2");
    measure(3, 1, 2, 32,  "R6 pre 3 with post 2");
  endtask

  task automatic t_slow();
    measure(7, 0, 1, 6,  "R4 R2 slow source skips pre 7");
    measure(5, 0, 3, 24, "R4 slow source skips pre 5");
    measure(2, 0, 0, 3,  "R11 slow tick paces output");
  endtask

  task automatic t_boundary();
    int w, hi, lo, hi2, lo2;
    restart();
    cfg_reg = word(0, 1, 3, 1);
    wait_high(w);
    repeat (3) @(negedge clk);
    cfg_reg = word(0, 1, 0, 1);
    count_phase(1'b1, hi);
    count_phase(1'b0, lo);
    count_phase(1'b1, hi2);
    count_phase(1'b0, lo2);
    check(hi + 3 == 8, "R9 high phase keeps old length", hi + 3, 8);
    check(lo == 8, "R9 low phase keeps old length", lo, 8);
    check(hi2 == 1, "R9 new ratio after boundary high", hi2, 1);
    check(lo2 == 1, "R9 new ratio after boundary low", lo2, 1);
  endtask

  task automatic t_disable();
    int w, hi, lo;
    restart();
    cfg_reg = word(0, 1, 3, 1);
    wait_high(w);
    repeat (3) @(negedge clk);
    cfg_reg = word(0, 1, 3, 0);
    count_phase(1'b1, hi);
    count_phase(1'b0, lo);
    check(hi + 3 == 8, "R8 high phase completes", hi + 3, 8);
    check(lo == CAP, "R8 output stays low after stop", lo, CAP);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    cfg_reg = 8'h00;
    fast_on = 1'b1;
    slow_on = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_fast_pre();
    t_post();
    t_slow();
    t_boundary();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule